// File: doc/BRIEF.md
# Bridge Interrupt Aggregation Controller

This block collects interrupt causes from the internal agents of a bus bridge and turns them into two level-sensitive, active-low interrupt lines: one toward the local processor and one toward the host. The causes are a host-to-local doorbell, a self-test request raised by a host configuration write, per-channel DMA completion (end of transfer or end of one descriptor in chaining mode), per-channel DMA terminal count, per-channel DMA abort, a non-empty outbound message queue, and master or target aborts on the bus. Each cause has its own enable bit. Each output also has a global enable. A single control/status register reports every enable and every pending cause, together with a three-bit field that records which agent owned the bus at the most recent abort.

The DMA engines, the message queue and the bus protocol logic sit outside the block. They present their events as single-cycle pulses or, for the queue, as a level. A routing bit per DMA channel sends all of that channel's causes either to the host line or to the local line. Latched causes are cleared by writing a one to their status bit. Level causes follow their input. Any interrupt can be removed either by clearing its enable or by removing its cause.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, every enable, every latched status, the doorbell bits and the owner field read as 0, and both `lint_n` and `hint_n` are 1.
- R2: A host doorbell write sets each doorbell bit written as 1 and leaves bits written as 0 unchanged. A local doorbell write clears each bit written as 1. When a set and a clear hit the same bit in the same cycle, the bit ends up set. Status bit 16 reads 1 when any doorbell bit is set.
- R3: `lint_n` is 0 exactly when local global enable (bit 0) is 1 and at least one local cause is active with its enable set. The local causes are: doorbell (enable bit 2), self-test (bit 3), DMA causes of channels routed local, and queue not empty (bit 10).
- R4: A `host_st_req` pulse sets the self-test status (bit 17). The status stays set until a CSR write with bit 17 at 1 clears it.
- R5: For channel c (0 or 1), a `dma_done` or `dma_desc_done` pulse sets done status bit 18+c, a `dma_tcount` pulse sets bit 20+c, and a `dma_abort` pulse sets bit 22+c. A CSR write with the matching bit at 1 clears it. An event in the same cycle as its clear leaves the bit set.
- R6: The causes of channel c are gated by enables 4+c (done), 6+c (terminal count) and 8+c (abort). They drive the host line when `dma_to_host[c]` is 1 and the local line when it is 0.
- R7: A `bus_mabort` or `bus_tabort` pulse loads `abort_owner` into bits 26:24, and does so again on every new abort. It also sets bit 28 (master abort) or bit 29 (target abort) respectively. Writing 1 to bit 28 or 29 clears that bit. Writing 0 leaves it unchanged.
- R8: Bit 27 follows `obq_not_empty` in the same cycle and is not latched.
- R9: `hint_n` is 0 exactly when host global enable (bit 1) is 1 and either a host-routed DMA cause is enabled and active, or bit 28 or 29 is set while bus-abort enable (bit 11) is 1.
- R10: Clearing an enable removes the interrupt it gated while the status bit stays set.
- R11: Every CSR write loads bits 11:0 as the enable set. Bits 30 and 31 read the asserted state of the local and host lines. Bits 15:12 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Local write strobe for the control/status register |
| csr_wdata | input | 32 | Write data: enables and write-1-to-clear status bits |
| csr_rdata | output | 32 | Control/status register readback |
| host_db_wr | input | 1 | Host doorbell write strobe (sets bits) |
| host_db_data | input | DB_W | Host doorbell write data |
| lcl_db_wr | input | 1 | Local doorbell write strobe (clears bits) |
| lcl_db_data | input | DB_W | Local doorbell write data |
| db_value | output | DB_W | Current doorbell bits |
| host_st_req | input | 1 | Self-test request pulse from a host configuration write |
| dma_done | input | 2 | Per-channel transfer-done pulse |
| dma_desc_done | input | 2 | Per-channel descriptor-complete pulse in chaining mode |
| dma_tcount | input | 2 | Per-channel terminal-count pulse |
| dma_abort | input | 2 | Per-channel DMA abort pulse |
| dma_to_host | input | 2 | Per-channel route select: 1 host, 0 local |
| obq_not_empty | input | 1 | Outbound queue not-empty level |
| bus_mabort | input | 1 | Master abort pulse |
| bus_tabort | input | 1 | Target abort pulse |
| abort_owner | input | 3 | Identity of the current bus master |
| lint_n | output | 1 | Local interrupt, active low, level |
| hint_n | output | 1 | Host interrupt, active low, level |

## Verification
The assertions rely on event inputs being pulses that the surrounding agents drive cleanly on the clock. They also rely on `abort_owner` being valid in any cycle where an abort pulse is present, and on all inputs being held at 0 while reset is active. The stimulus meets these conditions: it changes every input only at the falling clock edge, returns each pulse to 0 one cycle later, and presents the owner identity together with the abort pulse. Collisions are created on purpose only where a requirement defines the outcome, namely a set against a clear on the same doorbell bit and an event against its own write-one-to-clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NCH  = 2;
    localparam int DBW  = 8;
    localparam int IDW  = 3;
    localparam int CSRW = 32;

    // enable field positions
    localparam int EN_LGLB  = 0;
    localparam int EN_HGLB  = 1;
    localparam int EN_DB    = 2;
    localparam int EN_ST    = 3;
    localparam int EN_DONE  = 4;
    localparam int EN_TC    = EN_DONE + NCH;
    localparam int EN_DAB   = EN_TC + NCH;
    localparam int EN_OBQ   = EN_DAB + NCH;
    localparam int EN_BUSAB = EN_OBQ + 1;
    localparam int ENW      = EN_BUSAB + 1;

    // status field positions
    localparam int ST_DB   = 16;
    localparam int ST_ST   = 17;
    localparam int ST_DONE = 18;
    localparam int ST_TC   = ST_DONE + NCH;
    localparam int ST_DAB  = ST_TC + NCH;
    localparam int ST_ID   = 24;
    localparam int ST_OBQ  = ST_ID + IDW;
    localparam int ST_MA   = ST_OBQ + 1;
    localparam int ST_TA   = ST_MA + 1;
    localparam int ST_LOUT = ST_TA + 1;
    localparam int ST_HOUT = ST_LOUT + 1;

    typedef struct packed {
        logic [ENW-1:0] en;
        logic           st;
        logic           ma;
        logic           ta;
        logic [IDW-1:0] owner;
    } csr_state_t;
endpackage

// File: rtl/irq_db_reg.sv
module irq_db_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic [W-1:0] set_mask,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] bits_q,
    output logic         pend
);
    logic [W-1:0] bits_d;
    logic [W-1:0] clr_eff;
    logic [W-1:0] set_eff;

    always_comb begin
        clr_eff = clr_wr ? clr_mask : '0;
        set_eff = set_wr ? set_mask : '0;
        // a set that meets a clear on the same bit survives
        bits_d  = (bits_q & ~clr_eff) | set_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign pend = |bits_q;
endmodule

// File: rtl/irq_dma_stat.sv
module irq_dma_stat #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_done,
    input  logic [N-1:0] ev_desc,
    input  logic [N-1:0] ev_tc,
    input  logic [N-1:0] ev_ab,
    input  logic [N-1:0] clr_done,
    input  logic [N-1:0] clr_tc,
    input  logic [N-1:0] clr_ab,
    output logic [N-1:0] done_q,
    output logic [N-1:0] tc_q,
    output logic [N-1:0] ab_q
);
    typedef struct packed {
        logic [N-1:0] done;
        logic [N-1:0] tc;
        logic [N-1:0] ab;
    } dma_st_t;

    dma_st_t st_d;
    dma_st_t st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < N; c++) begin
            st_d.done[c] = (st_q.done[c] & ~clr_done[c]) | ev_done[c] | ev_desc[c];
            st_d.tc[c]   = (st_q.tc[c]   & ~clr_tc[c])   | ev_tc[c];
            st_d.ab[c]   = (st_q.ab[c]   & ~clr_ab[c])   | ev_ab[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_q = st_q.done;
    assign tc_q   = st_q.tc;
    assign ab_q   = st_q.ab;
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_agg_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic [ENW-1:0] en,
    input  logic           db_pend,
    input  logic           st,
    input  logic [N-1:0]   done,
    input  logic [N-1:0]   tc,
    input  logic [N-1:0]   ab,
    input  logic [N-1:0]   to_host,
    input  logic           obq,
    input  logic           ma,
    input  logic           ta,
    output logic           lcl_req,
    output logic           host_req
);
    logic [N-1:0] ch_cause;
    logic [N-1:0] ch_lcl;
    logic [N-1:0] ch_host;

    for (genvar g = 0; g < N; g++) begin : g_ch
        assign ch_cause[g] = (done[g] & en[EN_DONE + g])
                           | (tc[g]   & en[EN_TC + g])
                           | (ab[g]   & en[EN_DAB + g]);
        assign ch_lcl[g]   = ch_cause[g] & ~to_host[g];
        assign ch_host[g]  = ch_cause[g] &  to_host[g];
    end

    always_comb begin
        lcl_req  = en[EN_LGLB] & ((db_pend & en[EN_DB])
                                | (st & en[EN_ST])
                                | (obq & en[EN_OBQ])
                                | (|ch_lcl));
        host_req = en[EN_HGLB] & ((|ch_host)
                                | ((ma | ta) & en[EN_BUSAB]));
    end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int DB_W = DBW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic [CSRW-1:0] csr_wdata,
    output logic [CSRW-1:0] csr_rdata,
    input  logic            host_db_wr,
    input  logic [DB_W-1:0] host_db_data,
    input  logic            lcl_db_wr,
    input  logic [DB_W-1:0] lcl_db_data,
    output logic [DB_W-1:0] db_value,
    input  logic            host_st_req,
    input  logic [NCH-1:0]  dma_done,
    input  logic [NCH-1:0]  dma_desc_done,
    input  logic [NCH-1:0]  dma_tcount,
    input  logic [NCH-1:0]  dma_abort,
    input  logic [NCH-1:0]  dma_to_host,
    input  logic            obq_not_empty,
    input  logic            bus_mabort,
    input  logic            bus_tabort,
    input  logic [IDW-1:0]  abort_owner,
    output logic            lint_n,
    output logic            hint_n
);
    csr_state_t csr_d;
    csr_state_t csr_q;

    logic           db_pend;
    logic [NCH-1:0] done_q, tc_q, ab_q;
    logic [NCH-1:0] clr_done, clr_tc, clr_ab;
    logic           lcl_req, host_req;
    logic           unused_wbits;

    assign unused_wbits = ^{csr_wdata[ST_HOUT:ST_LOUT], csr_wdata[ST_OBQ:ST_ID],
                            csr_wdata[ST_DB], csr_wdata[ST_DB-1:ENW]};

    // write-one-to-clear strobes for the DMA status bits
    assign clr_done = csr_wr ? csr_wdata[ST_DONE +: NCH] : '0;
    assign clr_tc   = csr_wr ? csr_wdata[ST_TC   +: NCH] : '0;
    assign clr_ab   = csr_wr ? csr_wdata[ST_DAB  +: NCH] : '0;

    always_comb begin
        csr_d = csr_q;
        if (csr_wr) begin
            csr_d.en = csr_wdata[ENW-1:0];
            if (csr_wdata[ST_ST]) csr_d.st = 1'b0;
            if (csr_wdata[ST_MA]) csr_d.ma = 1'b0;
            if (csr_wdata[ST_TA]) csr_d.ta = 1'b0;
        end
        // new events override a clear in the same cycle
        if (host_st_req) csr_d.st = 1'b1;
        if (bus_mabort)  csr_d.ma = 1'b1;
        if (bus_tabort)  csr_d.ta = 1'b1;
        if (bus_mabort || bus_tabort) csr_d.owner = abort_owner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    irq_db_reg #(.W(DB_W)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wr   (host_db_wr),
        .set_mask (host_db_data),
        .clr_wr   (lcl_db_wr),
        .clr_mask (lcl_db_data),
        .bits_q   (db_value),
        .pend     (db_pend)
    );

    irq_dma_stat #(.N(NCH)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_done  (dma_done),
        .ev_desc  (dma_desc_done),
        .ev_tc    (dma_tcount),
        .ev_ab    (dma_abort),
        .clr_done (clr_done),
        .clr_tc   (clr_tc),
        .clr_ab   (clr_ab),
        .done_q   (done_q),
        .tc_q     (tc_q),
        .ab_q     (ab_q)
    );

    irq_route #(.N(NCH)) u_route (
        .en       (csr_q.en),
        .db_pend  (db_pend),
        .st       (csr_q.st),
        .done     (done_q),
        .tc       (tc_q),
        .ab       (ab_q),
        .to_host  (dma_to_host),
        .obq      (obq_not_empty),
        .ma       (csr_q.ma),
        .ta       (csr_q.ta),
        .lcl_req  (lcl_req),
        .host_req (host_req)
    );

    always_comb begin
        csr_rdata                 = '0;
        csr_rdata[ENW-1:0]        = csr_q.en;
        csr_rdata[ST_DB]          = db_pend;
        csr_rdata[ST_ST]          = csr_q.st;
        csr_rdata[ST_DONE +: NCH] = done_q;
        csr_rdata[ST_TC +: NCH]   = tc_q;
        csr_rdata[ST_DAB +: NCH]  = ab_q;
        csr_rdata[ST_ID +: IDW]   = csr_q.owner;
        csr_rdata[ST_OBQ]         = obq_not_empty;
        csr_rdata[ST_MA]          = csr_q.ma;
        csr_rdata[ST_TA]          = csr_q.ta;
        csr_rdata[ST_LOUT]        = lcl_req;
        csr_rdata[ST_HOUT]        = host_req;
    end

    assign lint_n = ~lcl_req;
    assign hint_n = ~host_req;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int DB_W = DBW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CSRW-1:0] csr_rdata,
    input logic            host_db_wr,
    input logic [DB_W-1:0] host_db_data,
    input logic [DB_W-1:0] db_value,
    input logic            host_st_req,
    input logic [NCH-1:0]  dma_done,
    input logic            bus_mabort,
    input logic            bus_tabort,
    input logic [IDW-1:0]  abort_owner,
    input logic            lint_n,
    input logic            hint_n
);
    AST_DB_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        host_db_wr |=> ((db_value & $past(host_db_data)) == $past(host_db_data))); // R2

    AST_LCL_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[EN_LGLB] |-> lint_n); // R3

    AST_ST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        host_st_req |=> csr_rdata[ST_ST]); // R4

    AST_DONE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done[0] |=> csr_rdata[ST_DONE]); // R5

    AST_OWNER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mabort || bus_tabort) |=> (csr_rdata[ST_ID +: IDW] == $past(abort_owner))); // R7

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_mabort || bus_tabort) |=> $stable(csr_rdata[ST_ID +: IDW])); // R7

    AST_HOST_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[EN_HGLB] |-> hint_n); // R9
endmodule

bind irq_agg_ctrl irq_agg_chk #(.DB_W(DB_W)) u_chk (.*);

// File: tb/test_irq_agg_ctrl.sv
module test_irq_agg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        host_db_wr = 1'b0;
    logic [7:0]  host_db_data = '0;
    logic        lcl_db_wr = 1'b0;
    logic [7:0]  lcl_db_data = '0;
    logic [7:0]  db_value;
    logic        host_st_req = 1'b0;
    logic [1:0]  dma_done = '0, dma_desc_done = '0, dma_tcount = '0, dma_abort = '0;
    logic [1:0]  dma_to_host = '0;
    logic        obq_not_empty = 1'b0;
    logic        bus_mabort = 1'b0, bus_tabort = 1'b0;
    logic [2:0]  abort_owner = '0;
    logic        lint_n, hint_n;

    always #10 clk = ~clk; // 50 MHz

    irq_agg_ctrl i_irq_agg_ctrl (.*);

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic        ln;
        logic        hn;
        logic [7:0]  db;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done_flag = 0;

    // reference state built from the requirements
    logic [11:0] en_m = '0;
    logic [7:0]  db_m = '0;
    logic        st_m = 0, ma_m = 0, ta_m = 0;
    logic [1:0]  dn_m = '0, tc_m = '0, ab_m = '0;
    logic [2:0]  id_m = '0;

    function automatic exp_t model_out(input string tag);
        exp_t e;
        logic lo, ho;
        lo = 0; ho = 0;
        for (int c = 0; c < 2; c++) begin
            logic cause;
            cause = (dn_m[c] & en_m[4+c]) | (tc_m[c] & en_m[6+c]) | (ab_m[c] & en_m[8+c]);
            if (dma_to_host[c]) ho |= cause; else lo |= cause;
        end
        lo = en_m[0] & (lo | ((|db_m) & en_m[2]) | (st_m & en_m[3]) | (obq_not_empty & en_m[10]));
        ho = en_m[1] & (ho | ((ma_m | ta_m) & en_m[11]));
        e.tag = tag;
        e.rd = '0;
        e.rd[11:0] = en_m;   e.rd[16] = |db_m;    e.rd[17] = st_m;
        e.rd[19:18] = dn_m;  e.rd[21:20] = tc_m;  e.rd[23:22] = ab_m;
        e.rd[26:24] = id_m;  e.rd[27] = obq_not_empty;
        e.rd[28] = ma_m;     e.rd[29] = ta_m;     e.rd[30] = lo; e.rd[31] = ho;
        e.ln = ~lo; e.hn = ~ho; e.db = db_m;
        return e;
    endfunction

    // driver: called at a falling edge with inputs already applied
    task automatic cyc(input string tag);
        if (csr_wr) begin
            en_m = csr_wdata[11:0];
            if (csr_wdata[17]) st_m = 0;
            dn_m &= ~csr_wdata[19:18];
            tc_m &= ~csr_wdata[21:20];
            ab_m &= ~csr_wdata[23:22];
            if (csr_wdata[28]) ma_m = 0;
            if (csr_wdata[29]) ta_m = 0;
        end
        if (lcl_db_wr)  db_m &= ~lcl_db_data;
        if (host_db_wr) db_m |= host_db_data;
        st_m |= host_st_req;
        dn_m |= dma_done | dma_desc_done;
        tc_m |= dma_tcount;
        ab_m |= dma_abort;
        ma_m |= bus_mabort;
        ta_m |= bus_tabort;
        if (bus_mabort || bus_tabort) id_m = abort_owner;
        q.push_back(model_out(tag));
        @(negedge clk);
        csr_wr = 0; host_db_wr = 0; lcl_db_wr = 0; host_st_req = 0;
        dma_done = '0; dma_desc_done = '0; dma_tcount = '0; dma_abort = '0;
        bus_mabort = 0; bus_tabort = 0;
    endtask

    task automatic wcsr(input logic [31:0] v);
        csr_wr = 1; csr_wdata = v;
    endtask

    // monitor: compares away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (csr_rdata !== e.rd || lint_n !== e.ln || hint_n !== e.hn || db_value !== e.db) begin
                    errors++;
                    $display("FAIL %s: rdata=%h lint_n=%b hint_n=%b db=%h expected rdata=%h lint_n=%b hint_n=%b db=%h",
                             e.tag, csr_rdata, lint_n, hint_n, db_value, e.rd, e.ln, e.hn, e.db);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc("R1 reset state");
        // doorbell set / no-effect / clear / collision
        host_db_wr = 1; host_db_data = 8'h05; cyc("R2 host set");
        host_db_wr = 1; host_db_data = 8'h00; cyc("R2 host zero write");
        wcsr(32'h0000_0005); cyc("R3 R11 enable doorbell");
        lcl_db_wr = 1; lcl_db_data = 8'h01; cyc("R2 local clear");
        host_db_wr = 1; host_db_data = 8'h01; lcl_db_wr = 1; lcl_db_data = 8'h05; cyc("R2 set wins");
        lcl_db_wr = 1; lcl_db_data = 8'h01; cyc("R3 level drops");
        // self-test request
        host_st_req = 1; cyc("R4 set while disabled");
        wcsr(32'h0000_000D); cyc("R4 enable self-test");
        wcsr(32'h0002_000D); cyc("R4 clear by write one");
        // DMA routing and status
        dma_to_host = 2'b10;
        wcsr(32'h0000_03F3); cyc("R6 enable all dma");
        dma_done[0] = 1; cyc("R5 R6 ch0 done local");
        dma_desc_done[1] = 1; cyc("R5 R6 ch1 descriptor host");
        dma_tcount[0] = 1; dma_abort[1] = 1; cyc("R5 tc and abort");
        dma_done[0] = 1; wcsr(32'h0004_03F3); cyc("R5 event beats clear");
        wcsr(32'h00FC_03F3); cyc("R5 clear all dma");
        dma_to_host = 2'b01; dma_done[0] = 1; cyc("R6 ch0 to host");
        dma_to_host = 2'b00; cyc("R6 ch0 back to local");
        wcsr(32'h0004_03F3); cyc("R5 clear done0");
        // queue level
        wcsr(32'h0000_0401); obq_not_empty = 1; cyc("R8 queue level on");
        obq_not_empty = 0; cyc("R8 queue level off");
        // bus aborts
        wcsr(32'h0000_0802); abort_owner = 3'd5; bus_mabort = 1; cyc("R7 R9 master abort");
        abort_owner = 3'd2; bus_tabort = 1; cyc("R7 target abort overwrites");
        wcsr(32'h0000_0802); cyc("R7 zero write keeps status");
        wcsr(32'h1000_0802); cyc("R7 clear master abort");
        wcsr(32'h0000_0002); cyc("R10 enable off keeps status");
        wcsr(32'h2000_0802); cyc("R9 clear target abort");
        host_db_wr = 1; host_db_data = 8'h80; wcsr(32'h0000_0004); cyc("R3 no global enable");
        wait (q.size() == 0);
        @(negedge clk);
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule